// File: doc/BRIEF.md
# Modem Line Monitor with Loopback

This block sits beside the register file of a 16550-style serial port and owns the modem side of it. Software writes a 5-bit control byte that drives the four handshake pins (request-to-send, terminal-ready and two general outputs). Software also reads a status byte whose upper nibble shows the four incoming handshake lines and whose lower nibble holds sticky change flags. The four incoming lines are asynchronous, so each one passes through a two-flop synchronizer before the block compares it with its last sampled level. Any difference sets the change flag for that line. The ring line is the exception: its flag is set only when the line falls.

Reading the status byte returns the current value, and the block clears the change flags on the clock edge that ends the read. A change that lands in that same cycle is kept. When the change flags are non-zero and the interrupt enable is high, a modem interrupt request is raised.

A loop control bit turns the block back on itself for self-test. The outgoing levels then feed the status nibble in place of the external lines, and the outgoing pins are held inactive.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status byte reads 0xB0 (bits 7, 5 and 4 set), the control byte reads 0x08, only the OUT2 pin is high, and the interrupt request is low.
- R2: A control write keeps only data bits 4:0, and reads of control bits 7:5 return zero. Bit 0 drives terminal-ready, bit 1 request-to-send, bit 2 OUT1, bit 3 OUT2, and bit 4 selects loopback. Outside loopback each pin follows its bit.
- R3: Status bits 4, 5 and 7 show the synchronized levels of clear-to-send, set-ready and carrier-detect. A change on any of them sets its flag: bit 0, bit 1 or bit 3.
- R4: Status bit 6 shows the ring line. Flag bit 2 is set when ring goes from 1 to 0 and is not set when it rises.
- R5: A status read returns the current byte, and after that edge the flags (bits 3:0) read zero while bits 7:4 are unchanged.
- R6: A flag stays set until a status read, even after its line returns to the old level.
- R7: In loopback, status bit 7 shows OUT2, bit 6 OUT1, bit 5 terminal-ready and bit 4 request-to-send. Changes of these mapped levels set the flags under the same rules as R3 and R4.
- R8: In loopback, changes on the external input lines have no effect on the status byte.
- R9: In loopback, the four outgoing pins are driven low whatever the control bits hold.
- R10: The interrupt request is high exactly when the enable input is high and any flag bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_in | input | 1 | External clear-to-send line, asynchronous |
| dsr_in | input | 1 | External set-ready line, asynchronous |
| dcd_in | input | 1 | External carrier-detect line, asynchronous |
| ri_in | input | 1 | External ring line, asynchronous |
| mcr_wr | input | 1 | Control register write strobe, one cycle |
| mcr_wdata | input | 8 | Control register write data |
| mcr_rdata | output | 8 | Control register read data |
| msr_rd | input | 1 | Status register read strobe; flags clear at the edge that ends it |
| msr_rdata | output | 8 | Status register read data |
| msi_en | input | 1 | Modem interrupt enable |
| rts_out | output | 1 | Request-to-send pin |
| dtr_out | output | 1 | Terminal-ready pin |
| out1_out | output | 1 | General output 1 pin |
| out2_out | output | 1 | General output 2 pin |
| msi_irq | output | 1 | Modem status interrupt request |

## Verification
The hardest case to reach from the ports is a ring trailing edge while in loopback. To reach it, the bench first enters loopback with OUT1 high, so the ring bit rises with no flag. It then clears the earlier flags with a read and writes OUT1 low, so the only flag that can appear is the falling-ring one. Leaving loopback is checked after the external lines have been moved while ignored and then restored. This shows that the move back to the external lines produces no false flags.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int NLINES = 4;
  localparam int MCR_W  = 5;
  // status nibble positions: {dcd, ri, dsr, cts}
  localparam int S_CTS = 0;
  localparam int S_DSR = 1;
  localparam int S_RI  = 2;
  localparam int S_DCD = 3;
  localparam logic [NLINES-1:0] STAT_RST = 4'b1011;
  localparam logic [MCR_W-1:0]  MCR_RST  = 5'b01000;

  function automatic logic [MCR_W-1:0] mcr_keep(input logic [7:0] v);
    return v[MCR_W-1:0];
  endfunction

  // loopback: dcd<-out2, ri<-out1, dsr<-dtr, cts<-rts
  function automatic logic [NLINES-1:0] loop_map(input logic [MCR_W-1:0] m);
    return {m[3], m[2], m[0], m[1]};
  endfunction

  // change flags: any toggle, except ring which counts only 1->0
  function automatic logic [NLINES-1:0] delta_calc(input logic [NLINES-1:0] prev,
                                                   input logic [NLINES-1:0] now);
    logic [NLINES-1:0] d;
    d = prev ^ now;
    d[S_RI] = prev[S_RI] & ~now[S_RI];
    return d;
  endfunction
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end
  assign q = sr[STAGES-1];
endmodule

// File: rtl/msu_mcr.sv
module msu_mcr
  import msu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic [MCR_W-1:0] mcr_q,
  output logic             loop_on,
  output logic             rts_o,
  output logic             dtr_o,
  output logic             out1_o,
  output logic             out2_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mcr_q <= MCR_RST;
    else if (wr) mcr_q <= mcr_keep(wdata);
  end

  assign loop_on = mcr_q[4];
  assign dtr_o   = mcr_q[0] & ~loop_on;
  assign rts_o   = mcr_q[1] & ~loop_on;
  assign out1_o  = mcr_q[2] & ~loop_on;
  assign out2_o  = mcr_q[3] & ~loop_on;

  p_mcr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mcr_q == $past(wdata[MCR_W-1:0])));
endmodule

// File: rtl/msu_msr_core.sv
module msu_msr_core
  import msu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] ext_stat,
  input  logic              loop_on,
  input  logic [MCR_W-1:0]  mcr_q,
  input  logic              rd,
  output logic [7:0]        msr
);
  logic [NLINES-1:0] stat_now;
  logic [NLINES-1:0] stat_prev;
  logic [NLINES-1:0] chg_bits;
  logic [NLINES-1:0] delta;

  assign stat_now = loop_on ? loop_map(mcr_q) : ext_stat;
  assign chg_bits = delta_calc(stat_prev, stat_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_prev <= STAT_RST;
      delta     <= '0;
    end else begin
      stat_prev <= stat_now;
      delta     <= (rd ? '0 : delta) | chg_bits;
    end
  end

  assign msr = {stat_now, delta};

  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> ((delta & ~$past(chg_bits)) == '0));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((delta & $past(delta)) == $past(delta)));
  p_ri_rise_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_now[S_RI] && !stat_prev[S_RI]) |=> (delta[S_RI] == $past(delta[S_RI] && !rd)));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       dcd_in,
  input  logic       ri_in,
  input  logic       mcr_wr,
  input  logic [7:0] mcr_wdata,
  output logic [7:0] mcr_rdata,
  input  logic       msr_rd,
  output logic [7:0] msr_rdata,
  input  logic       msi_en,
  output logic       rts_out,
  output logic       dtr_out,
  output logic       out1_out,
  output logic       out2_out,
  output logic       msi_irq
);
  logic [NLINES-1:0] ext_raw;
  logic [NLINES-1:0] ext_sync;
  logic [MCR_W-1:0]  mcr_q;
  logic              loop_on;

  assign ext_raw = {dcd_in, ri_in, dsr_in, cts_in};

  for (genvar i = 0; i < NLINES; i++) begin : g_sync
    msu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(STAT_RST[i])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_raw[i]), .q(ext_sync[i]));
  end

  msu_mcr u_mcr (
    .clk(clk), .rst_n(rst_n), .wr(mcr_wr), .wdata(mcr_wdata),
    .mcr_q(mcr_q), .loop_on(loop_on),
    .rts_o(rts_out), .dtr_o(dtr_out), .out1_o(out1_out), .out2_o(out2_out));

  msu_msr_core u_msr (
    .clk(clk), .rst_n(rst_n), .ext_stat(ext_sync), .loop_on(loop_on),
    .mcr_q(mcr_q), .rd(msr_rd), .msr(msr_rdata));

  assign mcr_rdata = {{(8-MCR_W){1'b0}}, mcr_q};
  assign msi_irq   = msi_en & (|msr_rdata[3:0]);

  p_loop_pins_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_rdata[4] |-> !(rts_out || dtr_out || out1_out || out2_out));
  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msi_irq |-> msi_en);
  p_ext_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_rdata[4] && $past(mcr_rdata[4]) && $stable(mcr_rdata)) |-> $stable(msr_rdata[7:4]));
endmodule

// File: tb/tb_modem_status_unit.sv
module tb_modem_status_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_in = 1'b1, dsr_in = 1'b1, dcd_in = 1'b1, ri_in = 1'b0;
  logic mcr_wr = 1'b0;
  logic [7:0] mcr_wdata = '0;
  logic [7:0] mcr_rdata;
  logic msr_rd = 1'b0;
  logic [7:0] msr_rdata;
  logic msi_en = 1'b0;
  logic rts_out, dtr_out, out1_out, out2_out, msi_irq;
  int n_checks = 0;
  int n_errs = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  modem_status_unit dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mcr(input logic [7:0] v);
    @(negedge clk); mcr_wr = 1'b1; mcr_wdata = v;
    @(negedge clk); mcr_wr = 1'b0;
    wait_n(2);
  endtask

  task automatic rd_msr(output logic [7:0] v);
    @(negedge clk); msr_rd = 1'b1; #1 v = msr_rdata;
    @(negedge clk); msr_rd = 1'b0;
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, rts_out, dtr_out, out1_out, out2_out};
  endfunction

  task automatic t_reset();
    chk("R1 msr", msr_rdata, 8'hB0);
    chk("R1 mcr", mcr_rdata, 8'h08);
    chk("R1 pins", pins(), 8'h01);
    chk("R1 irq", {7'b0, msi_irq}, 8'h00);
  endtask

  task automatic t_mcr();
    wr_mcr(8'hEF);
    chk("R2 mask", mcr_rdata, 8'h0F);
    chk("R2 pins", pins(), 8'h0F);
    wr_mcr(8'h05);
    chk("R2 pins dtr out1", pins(), 8'h06);
    chk("R2 no status effect", msr_rdata, 8'hB0);
    wr_mcr(8'h08);
  endtask

  task automatic t_lines();
    logic [7:0] v;
    cts_in = 1'b0; wait_n(4);
    chk("R3 cts", msr_rdata, 8'hA1);
    chk("R10 irq disabled", {7'b0, msi_irq}, 8'h00);
    msi_en = 1'b1; #1;
    chk("R10 irq enabled", {7'b0, msi_irq}, 8'h01);
    rd_msr(v);
    chk("R5 read value", v, 8'hA1);
    chk("R5 cleared", msr_rdata, 8'hA0);
    chk("R10 irq after clear", {7'b0, msi_irq}, 8'h00);
    dsr_in = 1'b0; wait_n(4);
    dsr_in = 1'b1; wait_n(4);
    chk("R6 sticky dsr", msr_rdata, 8'hA2);
    rd_msr(v);
    dcd_in = 1'b0; wait_n(4);
    chk("R3 dcd", msr_rdata, 8'h28);
    rd_msr(v);
    dcd_in = 1'b1; cts_in = 1'b1; wait_n(4);
    chk("R3 both back", msr_rdata, 8'hB9);
    rd_msr(v);
    chk("R5 clear keeps status", msr_rdata, 8'hB0);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    ri_in = 1'b1; wait_n(4);
    chk("R4 ri rise no flag", msr_rdata, 8'hF0);
    chk("R10 no irq on rise", {7'b0, msi_irq}, 8'h00);
    ri_in = 1'b0; wait_n(4);
    chk("R4 ri fall flag", msr_rdata, 8'hB4);
    rd_msr(v);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    wr_mcr(8'h10);
    chk("R7 loop all low", msr_rdata, 8'h0B);
    chk("R9 pins low", pins(), 8'h00);
    rd_msr(v);
    wr_mcr(8'h1F);
    chk("R7 loop all high", msr_rdata, 8'hFB);
    chk("R9 pins low all set", pins(), 8'h00);
    rd_msr(v);
    cts_in = 1'b0; dsr_in = 1'b0; dcd_in = 1'b0; ri_in = 1'b1; wait_n(4);
    chk("R8 ext ignored", msr_rdata, 8'hF0);
    wr_mcr(8'h1B);
    chk("R7 loop ri trailing", msr_rdata, 8'hB4);
    rd_msr(v);
    wr_mcr(8'h19);
    chk("R7 loop rts to cts", msr_rdata, 8'hA1);
    rd_msr(v);
    cts_in = 1'b1; dsr_in = 1'b1; dcd_in = 1'b1; ri_in = 1'b0; wait_n(4);
    wr_mcr(8'h1B);
    rd_msr(v);
    wr_mcr(8'h08);
    chk("R8 exit loop no flags", msr_rdata, 8'hB0);
    chk("R2 pins after loop", pins(), 8'h01);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_mcr();
    t_lines();
    t_ring();
    t_loop();
    finish_run();
  end
endmodule